// File: doc/BRIEF.md
# Alarm Countdown Timer

This block is a relative-delay alarm. Software writes a delay split into days, hours, minutes and seconds into a count register, then sets a run bit. On every one-second strobe the count goes down by one second. Borrows ripple from seconds to minutes, from minutes to hours and from hours to days. When the count reaches zero, a sticky pending flag is set and the count stays at zero.

The pending flag is gated by an interrupt-enable bit to form a level interrupt. Software clears the flag by writing one to the status bit. A write to the count register always reloads the countdown, even while it is running. When the count, run bit and interrupt enable are all zero, the alarm sits idle and cannot raise a flag.

The one-second strobe comes from outside, so the block has a single clock domain.

Top module: `alarm_countdown`

## Requirements
- R1: After reset the count register, run bit, interrupt enable and pending flag read as zero, and the interrupt output is low.
- R2: Byte offset 0x0C holds the count: seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days (8 bits, up to 255) from bit 21. The run bit is bit 8 at offset 0x14. The interrupt enable is bit 0 at offset 0x18. The pending flag is bit 0 at offset 0x1C. All other bits, and all other offsets, read as zero.
- R3: A strobe cycle with the run bit set and a nonzero count lowers the count by one second. Without a strobe, or with the run bit clear, the count holds.
- R4: Seconds at 0 become 59 and take a borrow from minutes. Minutes at 0 become 59 and take a borrow from hours. Hours at 0 become 23 and take a borrow from days.
- R5: The pending flag rises on the clock edge of the strobe that brings the count from one second to zero. Later strobes leave the count at zero.
- R6: While the count is zero, strobes with the run bit set raise no pending flag.
- R7: The interrupt output is high exactly while the pending flag and the interrupt enable are both set.
- R8: Writing 1 to bit 0 at 0x1C clears the pending flag. Writing 0 there has no effect. If a clearing write lands in the same cycle as the final strobe, the flag is set.
- R9: A count write while running reloads the countdown from the new value. When the write and a strobe fall in the same cycle, the written value wins and the strobe is discarded.
- R10: A delay of 255 days counts down through the day borrow to 254 days 23:59:59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe, once per second |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | ADDR_W | Write byte offset |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read byte offset |
| rdData | output | DATA_W | Read data (combinational) |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench targets each borrow chain: seconds only, seconds into hours, and all fields into days from the 255-day maximum. A design that wraps to 63 or 31 instead of 59 or 23, or that forgets the day borrow, reports a wrong count. It hits the final strobe from the one-second count to check that the flag appears on that edge and not one cycle late, and it sends strobes at a zero count, where a careless zero test would raise a false alarm. It also collides a clearing write with the final strobe and a reload with a strobe. A design that resolves either collision the wrong way either loses the alarm or counts one second off the fresh value.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam logic [7:0] OFS_COUNT  = 8'h0C;
  localparam logic [7:0] OFS_RUN    = 8'h14;
  localparam logic [7:0] OFS_IRQEN  = 8'h18;
  localparam logic [7:0] OFS_STATUS = 8'h1C;

  localparam int RUN_BIT   = 8;
  localparam int IRQEN_BIT = 0;
  localparam int PEND_BIT  = 0;

  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = 8;
  localparam int HR_LSB  = 16;
  localparam int DAY_LSB = 21;
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HR_W    = 5;

  typedef struct packed {
    logic loadCount;
    logic stepDown;
  } alarmStrobe_t;
endpackage

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  alarmStrobe_t      strobe,
  input  logic [DATA_W-1:0] loadWord,
  output logic [DATA_W-1:0] countWord,
  output logic              countZero,
  output logic              lastSecond
);
  logic [SEC_W-1:0] secQ, secNext;
  logic [MIN_W-1:0] minQ, minNext;
  logic [HR_W-1:0]  hrQ, hrNext;
  logic [DAY_W-1:0] dayQ, dayNext;
  logic secBorrow, minBorrow, hrBorrow;

  always_comb begin
    secBorrow = (secQ == '0);
    minBorrow = secBorrow && (minQ == '0);
    hrBorrow  = minBorrow && (hrQ == '0);
    secNext   = secBorrow ? SEC_W'(59) : secQ - SEC_W'(1);
    minNext   = minQ;
    if (secBorrow) minNext = (minQ == '0) ? MIN_W'(59) : minQ - MIN_W'(1);
    hrNext    = hrQ;
    if (minBorrow) hrNext = (hrQ == '0) ? HR_W'(23) : hrQ - HR_W'(1);
    dayNext   = hrBorrow ? dayQ - DAY_W'(1) : dayQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= '0;
      minQ <= '0;
      hrQ  <= '0;
      dayQ <= '0;
    end else if (strobe.loadCount) begin
      secQ <= loadWord[SEC_LSB +: SEC_W];
      minQ <= loadWord[MIN_LSB +: MIN_W];
      hrQ  <= loadWord[HR_LSB +: HR_W];
      dayQ <= loadWord[DAY_LSB +: DAY_W];
    end else if (strobe.stepDown) begin
      secQ <= secNext;
      minQ <= minNext;
      hrQ  <= hrNext;
      dayQ <= dayNext;
    end
  end

  always_comb begin
    countWord = '0;
    countWord[SEC_LSB +: SEC_W] = secQ;
    countWord[MIN_LSB +: MIN_W] = minQ;
    countWord[HR_LSB +: HR_W]   = hrQ;
    countWord[DAY_LSB +: DAY_W] = dayQ;
  end

  assign countZero  = (secQ == '0) && (minQ == '0) && (hrQ == '0) && (dayQ == '0);
  assign lastSecond = (secQ == SEC_W'(1)) && (minQ == '0) && (hrQ == '0) && (dayQ == '0);

  logic unusedLoad;
  assign unusedLoad = ^loadWord;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadCount && !strobe.stepDown) |=> $stable(countWord));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDown && !strobe.loadCount && secQ == '0) |=> (secQ == SEC_W'(59)));

  assert_hr_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDown && !strobe.loadCount && secQ == '0 && minQ == '0 && hrQ == '0)
      |=> (hrQ == HR_W'(23)));
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] countWord,
  input  logic              countZero,
  input  logic              lastSecond,
  output alarmStrobe_t      strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic runQ, irqEnQ, pendQ;
  logic hitCount, hitRun, hitIrqEn, hitStatus, setPend, clrPend;

  assign hitCount  = wrEn && (wrAddr == ADDR_W'(OFS_COUNT));
  assign hitRun    = wrEn && (wrAddr == ADDR_W'(OFS_RUN));
  assign hitIrqEn  = wrEn && (wrAddr == ADDR_W'(OFS_IRQEN));
  assign hitStatus = wrEn && (wrAddr == ADDR_W'(OFS_STATUS));

  assign strobe.loadCount = hitCount;
  assign strobe.stepDown  = secTick && runQ && !countZero && !hitCount;
  assign setPend = strobe.stepDown && lastSecond;
  assign clrPend = hitStatus && wrData[PEND_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      irqEnQ <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      if (hitRun)   runQ   <= wrData[RUN_BIT];
      if (hitIrqEn) irqEnQ <= wrData[IRQEN_BIT];
      if (setPend)      pendQ <= 1'b1;
      else if (clrPend) pendQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(OFS_COUNT))       rdData = countWord;
    else if (rdAddr == ADDR_W'(OFS_RUN))    rdData[RUN_BIT] = runQ;
    else if (rdAddr == ADDR_W'(OFS_IRQEN))  rdData[IRQEN_BIT] = irqEnQ;
    else if (rdAddr == ADDR_W'(OFS_STATUS)) rdData[PEND_BIT] = pendQ;
  end

  assign irqOut = pendQ && irqEnQ;

  logic unusedWr;
  assign unusedWr = ^wrData;

  assert_pend_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(secTick && runQ && !countZero));

  assert_zero_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (countZero && !pendQ) |=> !pendQ);

  assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !(wrEn && wrAddr == ADDR_W'(OFS_STATUS) && wrData[PEND_BIT])) |=> pendQ);

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !wrEn) |=> irqOut);
endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  alarmStrobe_t      strobe;
  logic [DATA_W-1:0] countWord;
  logic              countZero, lastSecond;

  alarm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .countWord(countWord), .countZero(countZero), .lastSecond(lastSecond),
    .strobe(strobe), .rdData(rdData), .irqOut(irqOut)
  );

  alarm_datapath #(.DATA_W(DATA_W), .DAY_W(DAY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadWord(wrData),
    .countWord(countWord), .countZero(countZero), .lastSecond(lastSecond)
  );
endmodule

// File: tb/alarm_countdown_tb.sv
`timescale 1ns/1ps
module alarm_countdown_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  int mSec = 0, mMin = 0, mHr = 0, mDay = 0;
  bit mRun = 0, mIe = 0, mPend = 0;

  always #2.5 clk = ~clk;

  alarm_countdown u_dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] modelRead(logic [4:0] a);
    logic [31:0] v = '0;
    case (a)
      5'h0C: v = (mDay << 21) | (mHr << 16) | (mMin << 8) | mSec;
      5'h14: v = {23'd0, mRun, 8'd0};
      5'h18: v = {31'd0, mIe};
      5'h1C: v = {31'd0, mPend};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit setNow;
    setNow = 0;
    if (!rstN) begin
      mSec = 0; mMin = 0; mHr = 0; mDay = 0; mRun = 0; mIe = 0; mPend = 0;
    end else begin
      if (wrEn && wrAddr == 5'h0C) begin
        mSec = wrData[5:0]; mMin = wrData[13:8]; mHr = wrData[20:16]; mDay = wrData[28:21];
      end else if (secTick && mRun && (mSec + mMin + mHr + mDay) != 0) begin
        if (mDay == 0 && mHr == 0 && mMin == 0 && mSec == 1) setNow = 1;
        if (mSec > 0) mSec--;
        else begin
          mSec = 59;
          if (mMin > 0) mMin--;
          else begin
            mMin = 59;
            if (mHr > 0) mHr--;
            else begin mHr = 23; mDay--; end
          end
        end
      end
      if (setNow) mPend = 1;
      else if (wrEn && wrAddr == 5'h1C && wrData[0]) mPend = 0;
      if (wrEn && wrAddr == 5'h14) mRun = wrData[8];
      if (wrEn && wrAddr == 5'h18) mIe = wrData[0];
    end
    #1.5;
    if (rstN && !finished) begin
      check("R2 readback vs model", rdData, modelRead(rdAddr));
      check("R7 irq vs model", {31'd0, irqOut}, {31'd0, mPend && mIe});
    end
  end

  task automatic step(bit tk, bit we, logic [4:0] a, logic [31:0] d);
    secTick = tk; wrEn = we; wrAddr = a; wrData = d;
    @(negedge clk);
    secTick = 0; wrEn = 0;
  endtask

  task automatic rd(string tag, logic [4:0] a, logic [31:0] exp);
    rdAddr = a; #0.1;
    check(tag, rdData, exp);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    rd("R1 count", 5'h0C, 0); rd("R1 run", 5'h14, 0);
    rd("R1 irqen", 5'h18, 0); rd("R1 pend", 5'h1C, 0);
    check("R1 irq", {31'd0, irqOut}, 0);
    rd("R2 unmapped", 5'h00, 0);

    step(0, 1, 5'h0C, 32'hFFFF_FFFF);
    rd("R2 count mask", 5'h0C, 32'h1FFF_3F3F);
    step(0, 1, 5'h14, 32'hFFFF_FFFF);
    rd("R2 run bit", 5'h14, 32'h100);
    step(0, 1, 5'h14, 0);

    step(0, 1, 5'h0C, 32'h205);
    step(1, 0, 0, 0);
    rd("R3 stopped hold", 5'h0C, 32'h205);
    step(0, 1, 5'h14, 32'h100);
    step(1, 0, 0, 0);
    rd("R3 decrement", 5'h0C, 32'h204);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    rd("R3 no tick hold", 5'h0C, 32'h204);

    step(0, 1, 5'h0C, 32'h1_0000);
    step(1, 0, 0, 0);
    rd("R4 hour borrow", 5'h0C, 32'h3B3B);
    step(0, 1, 5'h0C, 32'h20_0000);
    step(1, 0, 0, 0);
    rd("R4 day borrow", 5'h0C, 32'h17_3B3B);
    step(0, 1, 5'h0C, 32'h1FE0_0000);
    step(1, 0, 0, 0);
    rd("R10 max days", 5'h0C, 32'h1FD7_3B3B);

    step(0, 1, 5'h0C, 32'h2);
    step(1, 0, 0, 0);
    rd("R5 not yet", 5'h1C, 0);
    step(1, 0, 0, 0);
    rd("R5 pending", 5'h1C, 1);
    check("R7 gated off", {31'd0, irqOut}, 0);
    step(1, 0, 0, 0);
    rd("R5 stays zero", 5'h0C, 0);
    step(0, 1, 5'h18, 1);
    check("R7 irq high", {31'd0, irqOut}, 1);
    step(0, 1, 5'h1C, 0);
    rd("R8 write zero", 5'h1C, 1);
    step(0, 1, 5'h1C, 1);
    rd("R8 cleared", 5'h1C, 0);
    check("R8 irq low", {31'd0, irqOut}, 0);

    step(1, 0, 0, 0); step(1, 0, 0, 0);
    rd("R6 no pending at zero", 5'h1C, 0);

    step(0, 1, 5'h0C, 32'h5);
    step(1, 0, 0, 0);
    step(0, 1, 5'h0C, 32'hA);
    rd("R9 reload", 5'h0C, 32'hA);
    step(1, 1, 5'h0C, 32'h14);
    rd("R9 write wins", 5'h0C, 32'h14);

    step(0, 1, 5'h0C, 32'h1);
    step(1, 1, 5'h1C, 1);
    rd("R8 set wins", 5'h1C, 1);
    step(0, 1, 5'h1C, 1);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic [4:0] a;
      logic [31:0] d;
      rdAddr = 5'(4 * $urandom_range(0, 7));
      case ($urandom_range(0, 3))
        0: a = 5'h0C; 1: a = 5'h14; 2: a = 5'h18; default: a = 5'h1C;
      endcase
      d = $urandom;
      if (a == 5'h0C)
        d = ($urandom_range(0, 1) << 21) | ($urandom_range(0, 1) << 16) |
            ($urandom_range(0, 2) << 8) | $urandom_range(0, 3);
      step(r < 60, r > 88, a, d);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule